// File: doc/BRIEF.md
# Asymmetric-Width Dual-Clock Block RAM

This block is a true dual-port memory in which both ports address the same storage, each with its own word width. Port A is the narrow side. Port B is wider than port A by a power-of-two factor in data bits. Each port has its own clock, enable, write enable, address, write data, output-register reset and registered read data. The two ports can therefore live in unrelated clock domains, for example when a byte stream is gathered into wide words for a slower consumer.

Port widths are fixed by parameters. A requested width is rounded up to the next supported physical width: 1, 2, 4, 9, 18 or 36. The 9, 18 and 36 physical widths carry one parity-lane bit per eight data bits. These parity lanes are addressable from the narrow side only when that side is itself 9, 18 or 36 bits wide. Elaboration stops when the data-lane ratio is not a power of two, when the narrow side is wider than the wide side, or when the narrow address width is not the wide address width plus log2 of the ratio. When both ports write overlapping bits at the same time, the stored result is undefined.

Top module: `adwram_asym`

## Requirements
- R1: Narrow address N selects lane N mod RATIO of wide word N / RATIO, with lane 0 in the least significant data bits. In the default 9/36 configuration, narrow lane k holds wide data bits [8k+7:8k].
- R2: A narrow write changes only the data and parity bits of its own lane. The other lanes of that wide word keep their contents.
- R3: A wide write replaces every data lane and every parity bit of the addressed wide word.
- R4: A read is registered and appears on the port's output one clock after the enabled edge. When a port writes and reads the same address in one cycle, the output shows the contents from before that write.
- R5: While a port's enable is low, that port neither reads nor writes, whatever its write enable is, and its output register holds its value.
- R6: A port's output reset clears only that port's output register, on that port's own clock. It takes priority over a read in the same cycle. Memory contents and the other port's output are not changed.
- R7: When the narrow physical width is 9 or 18, each wide word reads as {parity bits, data bits}, with the parity bits in bits [WP+WD-1:WD]. Narrow lane k reads as {parity bits [k*NP +: NP], its data lane}. With the default 9/36 configuration, lane k is therefore {wide bit 32+k, wide bits [8k+7:8k]}.
- R8: When the narrow physical width is 1, 2 or 4, the parity bits of a wide word can be read and written only through the wide port. Narrow reads never show them and narrow writes never change them.
- R9: A requested width that is not supported is rounded up to the next supported width. The port's bits are the low bits of that physical word. Physical bits above the requested width are written as zero and dropped on read. For example, 13/26 maps to 18/36, with narrow lane k at wide data bits [16k+12:16k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Narrow port clock |
| rstA | input | 1 | Synchronous clear of the narrow output register |
| enA | input | 1 | Narrow port access enable |
| weA | input | 1 | Narrow port write enable, qualified by enA |
| addrA | input | NARROW_AW | Narrow word address |
| dinA | input | NARROW_W | Narrow write data |
| doutA | output | NARROW_W | Registered narrow read data |
| clkB | input | 1 | Wide port clock |
| rstB | input | 1 | Synchronous clear of the wide output register |
| enB | input | 1 | Wide port access enable |
| weB | input | 1 | Wide port write enable, qualified by enB |
| addrB | input | WIDE_AW | Wide word address |
| dinB | input | WIDE_W | Wide write data |
| doutB | output | WIDE_W | Registered wide read data |

## Verification
On every cycle of either clock, the assertions check that an output register holds its value when its port had neither an access nor a reset, and that it reads zero right after a reset. The lane order, the placement of the parity lanes, the preservation of neighbouring lanes, the read-first result and the width rounding all depend on data written on one clock and read back on the other. Only the directed scenarios can show those, each across three configurations: 9/36, 4/36 and 13/26.

// File: rtl/adwram_pkg.sv
package adwram_pkg;

  // Round a requested port width up to the next physical width.
  function automatic int legalWidth(input int req);
    if (req <= 1) return 1;
    if (req <= 2) return 2;
    if (req <= 4) return 4;
    if (req <= 9) return 9;
    if (req <= 18) return 18;
    return 36;
  endfunction

  // Data bits of a physical width (parity-capable widths hold 8 per 9).
  function automatic int dataLanes(input int w);
    return (w % 9 == 0) ? (w / 9) * 8 : w;
  endfunction

  // Parity bits of a physical width.
  function automatic int parLanes(input int w);
    return (w % 9 == 0) ? (w / 9) : 0;
  endfunction

  typedef struct packed {
    logic wr;   // store the port's write data this edge
    logic rd;   // load the output register this edge
    logic clr;  // clear the output register this edge
  } portStrobe_t;

endpackage

// File: rtl/adwram_port_ctrl.sv
module adwram_port_ctrl
  import adwram_pkg::*;
(
  input  logic        en,
  input  logic        we,
  input  logic        rst,
  output portStrobe_t stb
);

  // The enable gates every access; the reset only touches the output register.
  always_comb begin
    stb.wr  = en & we;
    stb.rd  = en;
    stb.clr = rst;
  end

endmodule

// File: rtl/adwram_store.sv
module adwram_store
  import adwram_pkg::*;
#(
  parameter int NARROW_W  = 9,
  parameter int WIDE_W    = 36,
  parameter int WIDE_AW   = 6,
  parameter int NARROW_AW = 8
)(
  input  logic                 clkA,
  input  portStrobe_t          stbA,
  input  logic [NARROW_AW-1:0] addrA,
  input  logic [NARROW_W-1:0]  dinA,
  output logic [NARROW_W-1:0]  doutA,
  input  logic                 clkB,
  input  portStrobe_t          stbB,
  input  logic [WIDE_AW-1:0]   addrB,
  input  logic [WIDE_W-1:0]    dinB,
  output logic [WIDE_W-1:0]    doutB
);

  localparam int PN    = legalWidth(NARROW_W);
  localparam int PW    = legalWidth(WIDE_W);
  localparam int ND    = dataLanes(PN);
  localparam int NP    = parLanes(PN);
  localparam int WD    = dataLanes(PW);
  localparam int WP    = parLanes(PW);
  localparam int RATIO = WD / ND;
  localparam int LOG_R = $clog2(RATIO);
  localparam int SLOTS = (1 << WIDE_AW) * RATIO;
  localparam int SW    = PN;  // one slot = one physical narrow word {par, data}

  // Two banks, one writer each; a slot's value is the XOR of both banks.
  logic [SW-1:0] bankA [SLOTS];
  logic [SW-1:0] bankB [SLOTS];

  // ---------------- narrow port ----------------
  logic [PN-1:0] physDinA;
  logic [SW-1:0] slotRdA;

  always_comb begin
    physDinA = '0;
    physDinA[NARROW_W-1:0] = dinA;
  end

  assign slotRdA = bankA[addrA] ^ bankB[addrA];

  always_ff @(posedge clkA) begin
    if (stbA.wr) bankA[addrA] <= physDinA ^ bankB[addrA];
  end

  always_ff @(posedge clkA) begin
    if (stbA.clr)     doutA <= '0;
    else if (stbA.rd) doutA <= slotRdA[NARROW_W-1:0];
  end

  if (NARROW_W < PN) begin : g_dropA
    logic unusedSlotA;
    assign unusedSlotA = ^slotRdA[PN-1:NARROW_W];
  end

  // ---------------- wide port ----------------
  logic [PW-1:0]        physDinB;
  logic [PW-1:0]        physRdB;
  logic [WD-1:0]        rdDataB;
  logic [NARROW_AW-1:0] bSlot   [RATIO];
  logic [SW-1:0]        slotInB [RATIO];
  logic [SW-1:0]        slotRdB [RATIO];

  always_comb begin
    physDinB = '0;
    physDinB[WIDE_W-1:0] = dinB;
  end

  for (genvar k = 0; k < RATIO; k++) begin : g_lane
    assign bSlot[k]   = (NARROW_AW'(addrB) << LOG_R) | NARROW_AW'(k);
    assign slotRdB[k] = bankA[bSlot[k]] ^ bankB[bSlot[k]];
    assign rdDataB[k*ND +: ND] = slotRdB[k][ND-1:0];
    if (NP > 0) begin : g_withPar
      assign slotInB[k] = {physDinB[WD + k*NP +: NP], physDinB[k*ND +: ND]};
    end else begin : g_dataOnly
      assign slotInB[k] = physDinB[k*ND +: ND];
    end
  end

  always_ff @(posedge clkB) begin
    if (stbB.wr) begin
      for (int k = 0; k < RATIO; k++) begin
        bankB[bSlot[k]] <= slotInB[k] ^ bankA[bSlot[k]];
      end
    end
  end

  if (NP > 0) begin : g_slotPar
    // Parity travels inside each slot, so both ports reach it.
    logic [WP-1:0] rdParB;
    for (genvar k = 0; k < RATIO; k++) begin : g_parLane
      assign rdParB[k*NP +: NP] = slotRdB[k][SW-1:ND];
    end
    assign physRdB = {rdParB, rdDataB};
  end else if (WP > 0) begin : g_widePar
    // Narrow side has no parity lanes: the wide port alone owns them.
    logic [WP-1:0] widePar [1 << WIDE_AW];
    always_ff @(posedge clkB) begin
      if (stbB.wr) widePar[addrB] <= physDinB[PW-1:WD];
    end
    assign physRdB = {widePar[addrB], rdDataB};
  end else begin : g_noPar
    assign physRdB = rdDataB;
  end

  always_ff @(posedge clkB) begin
    if (stbB.clr)     doutB <= '0;
    else if (stbB.rd) doutB <= physRdB[WIDE_W-1:0];
  end

  if (WIDE_W < PW) begin : g_dropB
    logic unusedWordB;
    assign unusedWordB = ^physRdB[PW-1:WIDE_W];
  end

  // ---------------- assertions ----------------
  AST_A_HOLD: assert property (@(posedge clkA) disable iff (stbA.clr)
    (!$past(stbA.rd) && !$past(stbA.clr)) |-> $stable(doutA))
    else $error("AST_A_HOLD"); // R5

  AST_B_HOLD: assert property (@(posedge clkB) disable iff (stbB.clr)
    (!$past(stbB.rd) && !$past(stbB.clr)) |-> $stable(doutB))
    else $error("AST_B_HOLD"); // R5

  AST_A_CLR: assert property (@(posedge clkA) disable iff (stbA.clr)
    $past(stbA.clr) |-> (doutA == '0))
    else $error("AST_A_CLR"); // R6

  AST_B_CLR: assert property (@(posedge clkB) disable iff (stbB.clr)
    $past(stbB.clr) |-> (doutB == '0))
    else $error("AST_B_CLR"); // R6

endmodule

// File: rtl/adwram_asym.sv
module adwram_asym
  import adwram_pkg::*;
#(
  parameter int NARROW_W  = 9,
  parameter int WIDE_W    = 36,
  parameter int WIDE_AW   = 6,
  parameter int NARROW_AW = 8
)(
  input  logic                 clkA,
  input  logic                 rstA,
  input  logic                 enA,
  input  logic                 weA,
  input  logic [NARROW_AW-1:0] addrA,
  input  logic [NARROW_W-1:0]  dinA,
  output logic [NARROW_W-1:0]  doutA,
  input  logic                 clkB,
  input  logic                 rstB,
  input  logic                 enB,
  input  logic                 weB,
  input  logic [WIDE_AW-1:0]   addrB,
  input  logic [WIDE_W-1:0]    dinB,
  output logic [WIDE_W-1:0]    doutB
);

  localparam int PN    = legalWidth(NARROW_W);
  localparam int PW    = legalWidth(WIDE_W);
  localparam int ND    = dataLanes(PN);
  localparam int NP    = parLanes(PN);
  localparam int WD    = dataLanes(PW);
  localparam int WP    = parLanes(PW);
  localparam int RATIO = (ND > 0) ? WD / ND : 0;

  // Elaboration guards on the width and depth parameters.
  if (NARROW_W < 1 || WIDE_W > 36 || PN > PW) begin : g_badWidth
    $error("adwram_asym: unsupported port widths");
  end
  if ((WD % ND) != 0 || RATIO < 1 || (RATIO & (RATIO - 1)) != 0) begin : g_badRatio
    $error("adwram_asym: data-lane ratio is not a power of two");
  end
  if (NARROW_AW != WIDE_AW + $clog2(RATIO)) begin : g_badAddr
    $error("adwram_asym: narrow address width disagrees with ratio");
  end
  if (NP > 0 && WP != NP * RATIO) begin : g_badPar
    $error("adwram_asym: parity lanes do not divide evenly");
  end

  portStrobe_t stbA, stbB;

  adwram_port_ctrl u_ctrlA (.en(enA), .we(weA), .rst(rstA), .stb(stbA));
  adwram_port_ctrl u_ctrlB (.en(enB), .we(weB), .rst(rstB), .stb(stbB));

  adwram_store #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .WIDE_AW  (WIDE_AW),
    .NARROW_AW(NARROW_AW)
  ) u_store (
    .clkA (clkA),
    .stbA (stbA),
    .addrA(addrA),
    .dinA (dinA),
    .doutA(doutA),
    .clkB (clkB),
    .stbB (stbB),
    .addrB(addrB),
    .dinB (dinB),
    .doutB(doutB)
  );

endmodule

// File: tb/adwram_asym_tb_top.sv
`timescale 1ns/1ps
module adwram_asym_tb_top;

  logic clkA = 1'b0, clkB = 1'b0;
  logic rstA, rstB;
  always #2.5 clkA = ~clkA;  // 200 MHz narrow clock
  always #3.5 clkB = ~clkB;  // unrelated wide clock

  // index 0: 9/36, index 1: 4/36, index 2: 13/26 (rounds to 18/36)
  logic        aEn [3];
  logic        aWe [3];
  logic [7:0]  aAddr [3];
  logic [12:0] aDin [3];
  logic        bEn [3];
  logic        bWe [3];
  logic [3:0]  bAddr [3];
  logic [35:0] bDin [3];
  logic [12:0] aQ [3];
  logic [35:0] bQ [3];

  logic [8:0]  q9A;
  logic [35:0] q9B;
  logic [3:0]  q4A;
  logic [35:0] q4B;
  logic [12:0] q13A;
  logic [25:0] q13B;

  assign aQ[0] = {4'b0, q9A};
  assign aQ[1] = {9'b0, q4A};
  assign aQ[2] = q13A;
  assign bQ[0] = q9B;
  assign bQ[1] = q4B;
  assign bQ[2] = {10'b0, q13B};

  adwram_asym #(.NARROW_W(9), .WIDE_W(36), .WIDE_AW(4), .NARROW_AW(6)) dut_i (
    .clkA(clkA), .rstA(rstA), .enA(aEn[0]), .weA(aWe[0]), .addrA(aAddr[0][5:0]),
    .dinA(aDin[0][8:0]), .doutA(q9A),
    .clkB(clkB), .rstB(rstB), .enB(bEn[0]), .weB(bWe[0]), .addrB(bAddr[0]),
    .dinB(bDin[0]), .doutB(q9B));

  adwram_asym #(.NARROW_W(4), .WIDE_W(36), .WIDE_AW(4), .NARROW_AW(7)) dut4_i (
    .clkA(clkA), .rstA(rstA), .enA(aEn[1]), .weA(aWe[1]), .addrA(aAddr[1][6:0]),
    .dinA(aDin[1][3:0]), .doutA(q4A),
    .clkB(clkB), .rstB(rstB), .enB(bEn[1]), .weB(bWe[1]), .addrB(bAddr[1]),
    .dinB(bDin[1]), .doutB(q4B));

  adwram_asym #(.NARROW_W(13), .WIDE_W(26), .WIDE_AW(4), .NARROW_AW(5)) dut13_i (
    .clkA(clkA), .rstA(rstA), .enA(aEn[2]), .weA(aWe[2]), .addrA(aAddr[2][4:0]),
    .dinA(aDin[2]), .doutA(q13A),
    .clkB(clkB), .rstB(rstB), .enB(bEn[2]), .weB(bWe[2]), .addrB(bAddr[2]),
    .dinB(bDin[2][25:0]), .doutB(q13B));

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- access tasks (drive on the falling edge, sample on the next one) ----
  task automatic wrA(input int d, input int addr, input logic [12:0] v);
    @(negedge clkA); aEn[d] = 1; aWe[d] = 1; aAddr[d] = 8'(addr); aDin[d] = v;
    @(negedge clkA); aEn[d] = 0; aWe[d] = 0;
  endtask

  task automatic rdA(input int d, input int addr, output logic [35:0] q);
    @(negedge clkA); aEn[d] = 1; aWe[d] = 0; aAddr[d] = 8'(addr);
    @(negedge clkA); aEn[d] = 0; q = {23'b0, aQ[d]};
  endtask

  task automatic rwA(input int d, input int addr, input logic [12:0] v, output logic [35:0] q);
    @(negedge clkA); aEn[d] = 1; aWe[d] = 1; aAddr[d] = 8'(addr); aDin[d] = v;
    @(negedge clkA); aEn[d] = 0; aWe[d] = 0; q = {23'b0, aQ[d]};
  endtask

  task automatic wrB(input int d, input int addr, input logic [35:0] v);
    @(negedge clkB); bEn[d] = 1; bWe[d] = 1; bAddr[d] = 4'(addr); bDin[d] = v;
    @(negedge clkB); bEn[d] = 0; bWe[d] = 0;
  endtask

  task automatic rdB(input int d, input int addr, output logic [35:0] q);
    @(negedge clkB); bEn[d] = 1; bWe[d] = 0; bAddr[d] = 4'(addr);
    @(negedge clkB); bEn[d] = 0; q = bQ[d];
  endtask

  task automatic rwB(input int d, input int addr, input logic [35:0] v, output logic [35:0] q);
    @(negedge clkB); bEn[d] = 1; bWe[d] = 1; bAddr[d] = 4'(addr); bDin[d] = v;
    @(negedge clkB); bEn[d] = 0; bWe[d] = 0; q = bQ[d];
  endtask

  // ---- scenarios ----
  task automatic tResetState();
    for (int d = 0; d < 3; d++) begin
      check("R6 reset narrow out", {23'b0, aQ[d]}, 36'h0);
      check("R6 reset wide out", bQ[d], 36'h0);
    end
  endtask

  task automatic tWideToNarrow();
    logic [35:0] q;
    wrB(0, 5, 36'hA_44332211);
    rdA(0, 20, q); check("R1 R7 lane0", q, 36'h011);
    rdA(0, 21, q); check("R1 R7 lane1", q, 36'h122);
    rdA(0, 22, q); check("R1 R7 lane2", q, 36'h033);
    rdA(0, 23, q); check("R1 R7 lane3", q, 36'h144);
  endtask

  task automatic tNarrowToWide();
    logic [35:0] q;
    wrA(0, 8, 13'h1F0);
    wrA(0, 9, 13'h00F);
    wrA(0, 10, 13'h1AA);
    wrA(0, 11, 13'h055);
    rdB(0, 2, q); check("R1 R7 narrow-built word", q, 36'h5_55AA0FF0);
  endtask

  task automatic tNarrowKeepsNeighbours();
    logic [35:0] q;
    wrA(0, 22, 13'h1EE);
    rdB(0, 5, q); check("R2 one lane replaced", q, 36'hE_44EE2211);
  endtask

  task automatic tWideFullWord();
    logic [35:0] q;
    wrB(0, 2, 36'h8_00000000);
    rdA(0, 8, q);  check("R3 lane0 cleared", q, 36'h000);
    rdA(0, 10, q); check("R3 lane2 parity cleared", q, 36'h000);
    rdA(0, 11, q); check("R3 lane3 parity set", q, 36'h100);
  endtask

  task automatic tReadFirst();
    logic [35:0] q;
    rwA(0, 22, 13'h077, q); check("R4 narrow read-first", q, 36'h1EE);
    rdA(0, 22, q);          check("R4 narrow new value", q, 36'h077);
    rwB(0, 5, 36'h0_12345678, q); check("R4 wide read-first", q, 36'hA_44772211);
    rdB(0, 5, q);                 check("R4 wide new value", q, 36'h0_12345678);
  endtask

  task automatic tEnableLow();
    logic [35:0] q;
    @(negedge clkA); aEn[0] = 0; aWe[0] = 1; aAddr[0] = 8'd20; aDin[0] = 13'h1FF;
    @(negedge clkA); aWe[0] = 0;
    check("R5 narrow out holds", {23'b0, aQ[0]}, 36'h077);
    rdA(0, 20, q); check("R5 narrow write blocked", q, 36'h078);
    @(negedge clkB); bEn[0] = 0; bWe[0] = 1; bAddr[0] = 4'd5; bDin[0] = '1;
    @(negedge clkB); bWe[0] = 0;
    check("R5 wide out holds", bQ[0], 36'h0_12345678);
    rdB(0, 5, q); check("R5 wide write blocked", q, 36'h0_12345678);
  endtask

  task automatic tOutputReset();
    logic [35:0] q;
    @(negedge clkA); rstA = 1; aEn[0] = 1; aWe[0] = 0; aAddr[0] = 8'd23;
    @(negedge clkA); rstA = 0; aEn[0] = 0;
    check("R6 reset beats read", {23'b0, aQ[0]}, 36'h0);
    check("R6 other port kept", bQ[0], 36'h0_12345678);
    rdA(0, 23, q); check("R6 contents kept", q, 36'h012);
  endtask

  task automatic tNibblePort();
    logic [35:0] q;
    wrB(1, 3, 36'hC_87654321);
    rdA(1, 24, q); check("R8 nibble lane0", q, 36'h1);
    rdA(1, 27, q); check("R8 nibble lane3", q, 36'h4);
    rdA(1, 31, q); check("R8 nibble lane7", q, 36'h8);
    wrA(1, 31, 13'hF);
    rdB(1, 3, q); check("R8 narrow write keeps parity", q, 36'hC_F7654321);
    wrB(1, 3, 36'h3_F7654321);
    rdA(1, 31, q); check("R8 parity invisible lane7", q, 36'hF);
    rdA(1, 30, q); check("R8 parity invisible lane6", q, 36'h7);
    rdB(1, 3, q); check("R8 wide parity updated", q, 36'h3_F7654321);
  endtask

  task automatic tOddWidths();
    logic [35:0] q;
    wrB(2, 1, 36'h0_03ABCDEF);
    rdA(2, 2, q); check("R9 rounded lane0", q, 36'h0DEF);
    rdA(2, 3, q); check("R9 rounded lane1", q, 36'h03AB);
    wrA(2, 3, 13'h1FFF);
    rdB(2, 1, q); check("R9 wide drops high bits", q, 36'h0_03FFCDEF);
    rdA(2, 3, q); check("R9 narrow full value", q, 36'h1FFF);
    rdA(2, 2, q); check("R9 neighbour lane kept", q, 36'h0DEF);
  endtask

  initial begin
    rstA = 1; rstB = 1;
    for (int d = 0; d < 3; d++) begin
      aEn[d] = 0; aWe[d] = 0; aAddr[d] = '0; aDin[d] = '0;
      bEn[d] = 0; bWe[d] = 0; bAddr[d] = '0; bDin[d] = '0;
    end
    repeat (4) @(negedge clkA);
    rstA = 0;
    @(negedge clkB);
    rstB = 0;
    @(negedge clkB);
    tResetState();
    tWideToNarrow();
    tNarrowToWide();
    tNarrowKeepsNeighbours();
    tWideFullWord();
    tReadFirst();
    tEnableLow();
    tOutputReset();
    tNibblePort();
    tOddWidths();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clkA);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog (R1..R9 run) actual=hung expected=complete");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule